// File: doc/BRIEF.md
# Level-Sensitive Scan Latch Chain

This block is a serial chain of scan cells for level-sensitive scan testing. Each cell holds two gated latches. Each latch has its own system data input and its own system gate. The first latch of a cell also takes a scan input, gated by scan clock A. The second latch takes its scan input from the first latch's output, gated by scan clock B. The second latch's output feeds the next cell, so the last cell's second latch drives the chain's scan output.

Normal operation and test operation are told apart only by which gates are pulsed. No mode-select input exists. In system use both scan clocks stay low, and each latch follows its system data while its system gate is high. In test use the system gates stay low. Pulsing A and then B, never together, moves the chain forward by one cell. After as many A/B pulse pairs as there are cells, the first bit shifted in appears at the scan output.

The latches are modelled as gated storage elements evaluated on every edge of a fast sampling clock `clk`. A gate that is held high for one or more sampling edges acts as a transparent window. When a latch's scan gate and system gate are high together, scan data wins.

Top module: `lssd_chain`

## Requirements
- R1: While `rst` is high at a rising edge of `clk`, every bit of `q1`, `q2` and `scan_out` becomes 0.
- R2: At a sampling edge with `scan_a` high, `q1[i]` takes the cell's scan source. For cell 0 the source is `scan_in`; for cell i>0 it is `q2[i-1]`, the value before the edge.
- R3: At a sampling edge with `scan_b` high, `q2[i]` takes the pre-edge value of `q1[i]` for every cell.
- R4: `scan_out` always equals `q2[N_CELLS-1]`.
- R5: At a sampling edge with `scan_a` low and `sys_clk1[i]` high, `q1[i]` takes `sys_d1[i]`. Latches whose gate is low keep their value.
- R6: At a sampling edge with `scan_b` low and `sys_clk2[i]` high, `q2[i]` takes `sys_d2[i]`. Latches whose gate is low keep their value.
- R7: A latch whose scan gate and system gate are both low holds its value, whatever its data inputs do.
- R8: When a latch's scan gate and system gate are high at the same edge (an illegal stimulus), the latch takes the scan source.
- R9: Shift bits b1..bj in with j A-then-B pulse pairs, starting from any state, where bit bk is on `scan_in` during the A pulse of pair k. After pair j, `q2[i]` equals b(j-i) for every i<j, and `scan_out` equals b(j-N_CELLS+1).
- R10: `scan_a` and `scan_b` are never high at the same sampling edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock at which all gates are evaluated |
| rst | input | 1 | Synchronous active-high reset, clears all latches |
| scan_a | input | 1 | Scan clock A, gates the first latch of every cell |
| scan_b | input | 1 | Scan clock B, gates the second latch of every cell |
| scan_in | input | 1 | Serial scan data into cell 0 |
| sys_clk1 | input | N_CELLS | System gate of each cell's first latch |
| sys_d1 | input | N_CELLS | System data of each cell's first latch |
| sys_clk2 | input | N_CELLS | System gate of each cell's second latch |
| sys_d2 | input | N_CELLS | System data of each cell's second latch |
| q1 | output | N_CELLS | First-latch outputs |
| q2 | output | N_CELLS | Second-latch outputs |
| scan_out | output | 1 | Serial scan data out of the last cell |

## Verification
The properties assume that scan clocks A and B never overlap. The ownership checks for system capture assume that the matching scan gate is low at the same edge. The bench drives every scan pulse as a single-edge window on one clock, with an idle edge between the fall of A and the rise of B. A monitor in the bench counts any A/B overlap as a failure. System gates are raised only while both scan clocks are low. The one exception is the deliberate collision case for R8, where the system gate and scan gate are driven high together and the design's scan priority is observed. All 256 patterns of an 8-bit word are shifted through the chain, and each is read back serially.

// File: rtl/lssd_pkg.sv
package lssd_pkg;

    localparam int DEF_CELLS = 8;

    typedef enum logic [1:0] {
        GATE_HOLD = 2'd0,
        GATE_SYS  = 2'd1,
        GATE_SCAN = 2'd2
    } gate_e;

    typedef struct packed {
        logic scan_clk;
        logic scan_d;
        logic sys_clk;
        logic sys_d;
    } latch_in_t;

    // scan gate wins over the system gate
    function automatic gate_e pick_gate(input logic scan_clk, input logic sys_clk);
        if (scan_clk)     return GATE_SCAN;
        else if (sys_clk) return GATE_SYS;
        else              return GATE_HOLD;
    endfunction

endpackage

// File: rtl/lssd_latch.sv
module lssd_latch
    import lssd_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  latch_in_t din,
    output logic      q
);

    gate_e sel;

    always_comb begin
        sel = pick_gate(din.scan_clk, din.sys_clk);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= 1'b0;
        end else begin
            case (sel)
                GATE_SCAN: q <= din.scan_d;
                GATE_SYS:  q <= din.sys_d;
                default:   q <= q;
            endcase
        end
    end

endmodule

// File: rtl/lssd_cell.sv
module lssd_cell
    import lssd_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic scan_a,
    input  logic scan_b,
    input  logic scan_src,
    input  logic sys_clk1,
    input  logic sys_d1,
    input  logic sys_clk2,
    input  logic sys_d2,
    output logic q1,
    output logic q2
);

    latch_in_t l1_in;
    latch_in_t l2_in;

    always_comb begin
        l1_in = '{scan_clk: scan_a, scan_d: scan_src, sys_clk: sys_clk1, sys_d: sys_d1};
        l2_in = '{scan_clk: scan_b, scan_d: q1,       sys_clk: sys_clk2, sys_d: sys_d2};
    end

    lssd_latch u_l1 (.clk(clk), .rst(rst), .din(l1_in), .q(q1));
    lssd_latch u_l2 (.clk(clk), .rst(rst), .din(l2_in), .q(q2));

endmodule

// File: rtl/lssd_chain.sv
module lssd_chain
    import lssd_pkg::*;
#(
    parameter int N_CELLS = DEF_CELLS
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               scan_a,
    input  logic               scan_b,
    input  logic               scan_in,
    input  logic [N_CELLS-1:0] sys_clk1,
    input  logic [N_CELLS-1:0] sys_d1,
    input  logic [N_CELLS-1:0] sys_clk2,
    input  logic [N_CELLS-1:0] sys_d2,
    output logic [N_CELLS-1:0] q1,
    output logic [N_CELLS-1:0] q2,
    output logic               scan_out
);

    localparam int LINKS = N_CELLS + 1;

    logic [LINKS-1:0] link;

    assign link[0] = scan_in;

    for (genvar i = 0; i < N_CELLS; i++) begin : g_cell
        lssd_cell u_cell (
            .clk      (clk),
            .rst      (rst),
            .scan_a   (scan_a),
            .scan_b   (scan_b),
            .scan_src (link[i]),
            .sys_clk1 (sys_clk1[i]),
            .sys_d1   (sys_d1[i]),
            .sys_clk2 (sys_clk2[i]),
            .sys_d2   (sys_d2[i]),
            .q1       (q1[i]),
            .q2       (q2[i])
        );
        assign link[i+1] = q2[i];
    end

    assign scan_out = link[N_CELLS];

endmodule

// File: rtl/lssd_chain_chk.sv
module lssd_chain_chk #(
    parameter int N_CELLS = 8
) (
    input logic               clk,
    input logic               rst,
    input logic               scan_a,
    input logic               scan_b,
    input logic               scan_in,
    input logic [N_CELLS-1:0] sys_clk1,
    input logic [N_CELLS-1:0] sys_d1,
    input logic [N_CELLS-1:0] sys_clk2,
    input logic [N_CELLS-1:0] sys_d2,
    input logic [N_CELLS-1:0] q1,
    input logic [N_CELLS-1:0] q2,
    input logic               scan_out
);

    assert_reset_clear_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (q1 == '0 && q2 == '0 && scan_out == 1'b0));

    assert_no_ab_overlap_R10: assert property (@(posedge clk) disable iff (rst)
        !(scan_a && scan_b));

    assert_b_copies_R3: assert property (@(posedge clk) disable iff (rst)
        scan_b |=> q2 == $past(q1));

    assert_out_last_R4: assert property (@(posedge clk) disable iff (rst)
        scan_out == q2[N_CELLS-1]);

    for (genvar i = 0; i < N_CELLS; i++) begin : g_chk
        if (i == 0) begin : g_head
            assert_a_shift_R2: assert property (@(posedge clk) disable iff (rst)
                scan_a |=> q1[0] == $past(scan_in));
        end else begin : g_body
            assert_a_shift_R2: assert property (@(posedge clk) disable iff (rst)
                scan_a |=> q1[i] == $past(q2[i-1]));
        end

        assert_sys1_R5: assert property (@(posedge clk) disable iff (rst)
            (!scan_a && sys_clk1[i]) |=> q1[i] == $past(sys_d1[i]));

        assert_sys2_R6: assert property (@(posedge clk) disable iff (rst)
            (!scan_b && sys_clk2[i]) |=> q2[i] == $past(sys_d2[i]));

        assert_hold1_R7: assert property (@(posedge clk) disable iff (rst)
            (!scan_a && !sys_clk1[i]) |=> $stable(q1[i]));

        assert_hold2_R7: assert property (@(posedge clk) disable iff (rst)
            (!scan_b && !sys_clk2[i]) |=> $stable(q2[i]));
    end

endmodule

bind lssd_chain lssd_chain_chk #(.N_CELLS(N_CELLS)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .scan_a   (scan_a),
    .scan_b   (scan_b),
    .scan_in  (scan_in),
    .sys_clk1 (sys_clk1),
    .sys_d1   (sys_d1),
    .sys_clk2 (sys_clk2),
    .sys_d2   (sys_d2),
    .q1       (q1),
    .q2       (q2),
    .scan_out (scan_out)
);

// File: tb/lssd_chain_test.sv
`timescale 1ns/1ps
module lssd_chain_test;

    localparam int N = 8;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         scan_a = 1'b0;
    logic         scan_b = 1'b0;
    logic         scan_in = 1'b0;
    logic [N-1:0] sys_clk1 = '0;
    logic [N-1:0] sys_d1 = '0;
    logic [N-1:0] sys_clk2 = '0;
    logic [N-1:0] sys_d2 = '0;
    logic [N-1:0] q1;
    logic [N-1:0] q2;
    logic         scan_out;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    lssd_chain #(.N_CELLS(N)) uut (
        .clk(clk), .rst(rst), .scan_a(scan_a), .scan_b(scan_b), .scan_in(scan_in),
        .sys_clk1(sys_clk1), .sys_d1(sys_d1), .sys_clk2(sys_clk2), .sys_d2(sys_d2),
        .q1(q1), .q2(q2), .scan_out(scan_out)
    );

    task automatic check(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // R10 stimulus monitor: overlap of the two scan clocks counts as a failure
    always @(posedge clk) begin
        if (!rst && scan_a && scan_b) begin
            failures++;
            $display("FAIL R10 actual=overlap expected=no_overlap");
        end
    end

    // one A window then one B window, each one sampling edge wide
    task automatic pulse_pair(input logic bit_in);
        scan_in = bit_in;
        scan_a = 1'b1;
        @(negedge clk);
        scan_a = 1'b0;
        @(negedge clk);
        scan_b = 1'b1;
        @(negedge clk);
        scan_b = 1'b0;
        @(negedge clk);
    endtask

    function automatic logic [N-1:0] rev(input logic [N-1:0] v);
        logic [N-1:0] r;
        for (int k = 0; k < N; k++) r[k] = v[N-1-k];
        return r;
    endfunction

    initial begin
        logic [N-1:0] old1, old2, mask, data, stream;
        repeat (3) @(negedge clk);
        check("R1", q1, '0);
        check("R1", q2, '0);
        check("R1", {{(N-1){1'b0}}, scan_out}, '0);
        rst = 1'b0;
        @(negedge clk);

        // R5 and R6: system captures with the scan clocks low
        for (int m = 0; m < 16; m++) begin
            mask = N'((m * 37 + 5) & ((1 << N) - 1));
            data = N'((m * 91 + 22) & ((1 << N) - 1));
            old1 = q1;
            old2 = q2;
            sys_clk1 = mask;  sys_d1 = data;
            sys_clk2 = ~mask; sys_d2 = ~data ^ mask;
            @(negedge clk);
            sys_clk1 = '0; sys_clk2 = '0;
            check("R5", q1, (mask & data) | (~mask & old1));
            check("R6", q2, (~mask & (~data ^ mask)) | (mask & old2));
        end

        // R7: all gates low, data toggles, no change
        old1 = q1; old2 = q2;
        for (int k = 0; k < 6; k++) begin
            sys_d1 = ~sys_d1; sys_d2 = N'(k * 29); scan_in = ~scan_in;
            @(negedge clk);
        end
        check("R7", q1, old1);
        check("R7", q2, old2);

        // R8: scan gate A collides with system gate 1
        old2 = q2;
        scan_in = 1'b1;
        sys_d1 = ~({old2[N-2:0], 1'b1});
        sys_clk1 = '1;
        scan_a = 1'b1;
        @(negedge clk);
        scan_a = 1'b0; sys_clk1 = '0;
        @(negedge clk);
        check("R8", q1, {old2[N-2:0], 1'b1});
        // R2 and R3 single step
        scan_b = 1'b1;
        @(negedge clk);
        scan_b = 1'b0;
        @(negedge clk);
        check("R3", q2, {old2[N-2:0], 1'b1});
        check("R4", {{(N-1){1'b0}}, scan_out}, {{(N-1){1'b0}}, old2[N-2]});

        // R9 and R2: every N-bit pattern shifted in, then read back serially
        for (int p = 0; p < (1 << N); p++) begin
            data = N'(p);
            for (int k = 0; k < N; k++) pulse_pair(data[k]);
            check("R9", q2, rev(data));
            check("R2", q1, rev(data));
            stream = '0;
            for (int k = 0; k < N; k++) begin
                stream[k] = scan_out;
                pulse_pair(1'b0);
            end
            check("R9", stream, data);
        end

        // R1: reset from a loaded state
        for (int k = 0; k < N; k++) pulse_pair(1'b1);
        rst = 1'b1;
        @(negedge clk);
        check("R1", q1, '0);
        check("R1", q2, '0);
        rst = 1'b0;
        @(negedge clk);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule